// File: doc/BRIEF.md
# Start-up Event Sequencer

This block takes a device from configuration into user operation. It drives three start-up events: the done indication rising, the global set/reset being let go, and the user I/O drivers being switched on. A configuration select picks the moment of each event inside a short window that opens once loading has finished. Any event can therefore fall one clock ahead of another, one clock behind it, or in the same clock.

After power-on reset or a program request, the sequencer spends a fixed number of clocks clearing and holds the init output low. It then raises init and waits in the configuration phase until `cfg_done_i` is sampled high. That edge opens the window and captures the three selects. Each event turns on in its chosen slot and then stays on. In the third window clock the sequencer enters user mode and the two status flags swap levels. Only a new program request returns it to the clearing phase.

The four states are CLEAR, CONFIG, WINDOW and USER. The transitions are:
- CLEAR to CONFIG when the clearing count expires.
- CONFIG to WINDOW when the configuration-complete input is sampled high.
- WINDOW to USER on the last window clock.
- Any state to CLEAR when a program request is sampled.

Top module: `startup_sequencer`

## Requirements
- R1: While reset is applied, and in the clearing phase, done_o=0, gsr_o=1, io_en_o=0, init_o=0, hi_stat_o=1 and lo_stat_o=0.
- R2: init_o rises on the CLR_CYCLES-th rising edge (default 8), counted from the first edge after reset is released or the first edge that samples prog_req_i low. Before that edge it stays 0.
- R3: In the configuration phase, before the window opens, done_o=0, gsr_o=1, io_en_o=0, hi_stat_o=1, lo_stat_o=0 and init_o=1.
- R4: Let E0 be the edge that samples cfg_done_i=1 in the configuration phase. An event whose 2-bit select is 0, 1 or 2 turns on at edge E0+1, E0+2 or E0+3 respectively. Each select chooses its event on its own.
- R5: A select value of 3 behaves exactly like value 2.
- R6: The selects are captured at E0. Changes to them after E0 have no effect on the current window.
- R7: Once an event is on, it stays on until a program request is sampled. Toggling cfg_done_i in user mode has no effect.
- R8: At E0+3, lo_stat_o goes to 1 and hi_stat_o goes to 0, at the same edge as the slot-2 events.
- R9: A program request is synchronous and has priority in every state. The edge that samples prog_req_i=1 returns all outputs to the R1 levels, and they stay there while prog_req_i is held.
- R10: cfg_done_i is ignored during clearing. If cfg_done_i is already high when clearing ends, the window opens on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| prog_req_i | input | 1 | Synchronous program request, restarts clearing |
| cfg_done_i | input | 1 | Configuration data fully loaded |
| sel_done_i | input | SEL_W | Window slot for the done event |
| sel_gsr_i | input | SEL_W | Window slot for the set/reset release |
| sel_io_i | input | SEL_W | Window slot for the I/O enable |
| done_o | output | 1 | Done indication |
| gsr_o | output | 1 | Global set/reset, high while held |
| io_en_o | output | 1 | User I/O driver enable |
| init_o | output | 1 | Init status, low while clearing |
| hi_stat_o | output | 1 | High-status flag, high until user mode |
| lo_stat_o | output | 1 | Low-status flag, high in user mode |

## Verification
Every output is registered. An event chosen by select s is due exactly s+1 edges after E0, with 3 counted as 2. The status swap is due at E0+3, and the clearing release is due CLR_CYCLES edges after the request drops. The bench samples one time unit after each rising edge and compares each output against a bench function of the select captured at E0 and the edge count since E0. It also checks the cycle before each event is due, so that an event arriving early or late is caught.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_CONFIG = 2'd1,
        ST_WINDOW = 2'd2,
        ST_USER   = 2'd3
    } seq_state_e;

    localparam int NUM_EVT = 3;
    localparam int EV_DONE = 0;
    localparam int EV_GSR  = 1;
    localparam int EV_IO   = 2;

endpackage

// File: rtl/startup_step_ctr.sv
module startup_step_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (en) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/startup_event_slot.sv
module startup_event_slot #(
    parameter int SEL_W   = 2,
    parameter int WIN_LEN = 3,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             win_act,
    input  logic [CNT_W-1:0] step_i,
    output logic             fire_o
);

    localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(WIN_LEN - 1);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] slot;

    // selects past the window end saturate onto the last slot
    always_comb begin
        slot = (sel_q > LAST_SLOT) ? LAST_SLOT : sel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            fire_o <= 1'b0;
        end else if (clr) begin
            sel_q  <= '0;
            fire_o <= 1'b0;
        end else begin
            if (cap) begin
                sel_q <= sel_i;
            end
            if (win_act && (int'(slot) == int'(step_i))) begin
                fire_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
    import startup_seq_pkg::*;
#(
    parameter int CLR_CYCLES = 8,
    parameter int WIN_LEN    = 3,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_req_i,
    input  logic             cfg_done_i,
    input  logic [CNT_W-1:0] step_i,
    output seq_state_e       state_o,
    output logic             ctr_clr_o,
    output logic             ctr_en_o,
    output logic             cap_o,
    output logic             win_act_o
);

    localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYCLES - 1);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(WIN_LEN - 1);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (prog_req_i) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR:  if (step_i == CLR_LAST) state_d = ST_CONFIG;
                ST_CONFIG: if (cfg_done_i)         state_d = ST_WINDOW;
                ST_WINDOW: if (step_i == WIN_LAST) state_d = ST_USER;
                ST_USER:   state_d = ST_USER;
                default:   state_d = ST_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctr_clr_o = prog_req_i || (state_d != state_q) || (state_q == ST_CONFIG);
        ctr_en_o  = (state_q == ST_CLEAR) || (state_q == ST_WINDOW);
        cap_o     = (state_q == ST_CONFIG) && cfg_done_i && !prog_req_i;
        win_act_o = (state_q == ST_WINDOW);
    end

    assign state_o = state_q;

endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
    import startup_seq_pkg::*;
#(
    parameter int CLR_CYCLES = 8,
    parameter int WIN_LEN    = 3,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_req_i,
    input  logic             cfg_done_i,
    input  logic [SEL_W-1:0] sel_done_i,
    input  logic [SEL_W-1:0] sel_gsr_i,
    input  logic [SEL_W-1:0] sel_io_i,
    output logic             done_o,
    output logic             gsr_o,
    output logic             io_en_o,
    output logic             init_o,
    output logic             hi_stat_o,
    output logic             lo_stat_o
);

    localparam int CNT_MAX = (CLR_CYCLES > WIN_LEN) ? CLR_CYCLES : WIN_LEN;
    localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    seq_state_e       state;
    logic             ctr_clr;
    logic             ctr_en;
    logic             cap;
    logic             win_act;
    logic [CNT_W-1:0] step;
    logic [SEL_W-1:0] sel_arr [NUM_EVT];
    logic [NUM_EVT-1:0] fire;

    assign sel_arr[EV_DONE] = sel_done_i;
    assign sel_arr[EV_GSR]  = sel_gsr_i;
    assign sel_arr[EV_IO]   = sel_io_i;

    startup_fsm #(
        .CLR_CYCLES (CLR_CYCLES),
        .WIN_LEN    (WIN_LEN),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_req_i (prog_req_i),
        .cfg_done_i (cfg_done_i),
        .step_i     (step),
        .state_o    (state),
        .ctr_clr_o  (ctr_clr),
        .ctr_en_o   (ctr_en),
        .cap_o      (cap),
        .win_act_o  (win_act)
    );

    startup_step_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .en    (ctr_en),
        .cnt_o (step)
    );

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        startup_event_slot #(
            .SEL_W   (SEL_W),
            .WIN_LEN (WIN_LEN),
            .CNT_W   (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (prog_req_i),
            .cap     (cap),
            .sel_i   (sel_arr[e]),
            .win_act (win_act),
            .step_i  (step),
            .fire_o  (fire[e])
        );
    end

    always_comb begin
        done_o    = fire[EV_DONE];
        gsr_o     = !fire[EV_GSR];
        io_en_o   = fire[EV_IO];
        init_o    = (state != ST_CLEAR);
        hi_stat_o = (state != ST_USER);
        lo_stat_o = (state == ST_USER);
    end

endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_req_i,
    input logic cfg_done_i,
    input logic done_o,
    input logic gsr_o,
    input logic io_en_o,
    input logic init_o,
    input logic hi_stat_o,
    input logic lo_stat_o
);

    p_hold_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !init_o |-> (!done_o && gsr_o && !io_en_o && hi_stat_o && !lo_stat_o))
        else $error("hold levels broken while init low (R1/R3)");

    p_prog_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_i |=> (!init_o && !done_o && gsr_o && !io_en_o))
        else $error("program request did not clear outputs (R9)");

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !prog_req_i) |=> done_o)
        else $error("done dropped without program request (R7)");

    p_gsr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gsr_o && !prog_req_i) |=> !gsr_o)
        else $error("set/reset re-applied without program request (R7)");

    p_io_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en_o && !prog_req_i) |=> io_en_o)
        else $error("I/O enable dropped without program request (R7)");

    p_user_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stat_o |-> (done_o && !gsr_o && io_en_o && !hi_stat_o))
        else $error("user mode reached before all events (R8)");

    p_init_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_o) |-> !$past(prog_req_i))
        else $error("init rose straight after a program request (R2)");

endmodule

bind startup_sequencer startup_sequencer_chk u_chk (.*);

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;

    localparam int CLR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_req_i = 1'b0;
    logic       cfg_done_i = 1'b0;
    logic [1:0] sel_done_i = '0;
    logic [1:0] sel_gsr_i = '0;
    logic [1:0] sel_io_i = '0;
    logic       done_o, gsr_o, io_en_o, init_o, hi_stat_o, lo_stat_o;

    int vectors = 0;
    int miscomp = 0;

    always #4 clk = ~clk;

    startup_sequencer #(.CLR_CYCLES(CLR), .WIN_LEN(3), .SEL_W(2)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_req_i (prog_req_i),
        .cfg_done_i (cfg_done_i),
        .sel_done_i (sel_done_i),
        .sel_gsr_i  (sel_gsr_i),
        .sel_io_i   (sel_io_i),
        .done_o     (done_o),
        .gsr_o      (gsr_o),
        .io_en_o    (io_en_o),
        .init_o     (init_o),
        .hi_stat_o  (hi_stat_o),
        .lo_stat_o  (lo_stat_o)
    );

    function automatic int slot_of(input int s);
        return (s > 2) ? 2 : s;
    endfunction

    function automatic logic on_at(input int s, input int k);
        return (k > slot_of(s));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e_done, input logic e_gsr,
                           input logic e_io, input logic e_init, input logic e_hi,
                           input logic e_lo);
        chk(req, "done_o", done_o, e_done);
        chk(req, "gsr_o", gsr_o, e_gsr);
        chk(req, "io_en_o", io_en_o, e_io);
        chk(req, "init_o", init_o, e_init);
        chk(req, "hi_stat_o", hi_stat_o, e_hi);
        chk(req, "lo_stat_o", lo_stat_o, e_lo);
    endtask

    // clearing phase: init low for CLR-1 edges, high on the CLR-th
    task automatic wait_clear(input string req);
        for (int i = 1; i < CLR; i++) begin
            tick();
            chk_all(req, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        end
        tick();
        chk_all("R2", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic idle_config(input int n);
        cfg_done_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            chk_all("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic run_window(input int sd, input int sg, input int si, input bit mutate);
        string req;
        req = (sd == 3 || sg == 3 || si == 3) ? "R5" : (mutate ? "R6" : "R4");
        sel_done_i = 2'(sd);
        sel_gsr_i  = 2'(sg);
        sel_io_i   = 2'(si);
        cfg_done_i = 1'b1;
        tick();                                  // E0
        chk_all("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        if (mutate) begin                        // R6: post-capture changes ignored
            sel_done_i = 2'(3 - sd);
            sel_gsr_i  = 2'(3 - sg);
            sel_io_i   = 2'(3 - si);
        end
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk(req, "done_o", done_o, on_at(sd, k));
            chk(req, "gsr_o", gsr_o, !on_at(sg, k));
            chk(req, "io_en_o", io_en_o, on_at(si, k));
            chk("R8", "lo_stat_o", lo_stat_o, k == 3);
            chk("R8", "hi_stat_o", hi_stat_o, k != 3);
        end
        for (int i = 0; i < 3; i++) begin       // R7: sticky in user mode
            cfg_done_i = 1'($urandom % 2);
            tick();
            chk_all("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        end
        prog_req_i = 1'b1;
        tick();
        chk_all("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        prog_req_i = 1'b0;
        cfg_done_i = 1'b0;
        wait_clear("R1");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk_all("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        tick();
        tick();
        chk_all("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        cfg_done_i = 1'b1;                       // R10: ignored while clearing
        wait_clear("R10");
        run_window(0, 1, 2, 1'b0);               // window opens on next edge (R10)

        idle_config(3);
        run_window(2, 1, 0, 1'b0);
        idle_config(1);
        run_window(3, 3, 0, 1'b0);
        idle_config(2);
        run_window(1, 1, 1, 1'b0);
        idle_config(1);
        run_window(0, 2, 3, 1'b1);

        // program request mid-window, held for several edges (R9)
        idle_config(1);
        sel_done_i = 2'd0; sel_gsr_i = 2'd0; sel_io_i = 2'd1;
        cfg_done_i = 1'b1;
        tick();
        tick();
        chk_all("R4", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        prog_req_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_all("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        end
        prog_req_i = 1'b0;
        cfg_done_i = 1'b0;
        wait_clear("R9");

        for (int it = 0; it < 30; it++) begin
            idle_config(int'($urandom % 4));
            run_window(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                       1'($urandom % 2));
        end
        finish_run();
    end

endmodule